// File: doc/BRIEF.md
# Two-Channel Direction-Programmable GPIO Register Bank

This block holds the output-value and direction registers of one or two general-purpose pin channels, reached through a plain 32-bit register port made of an address, a write strobe, four byte enables, write data and a registered read-data bus. Each channel has its own output-value vector, its own high-impedance control vector and an input vector for the pin levels. The input vector is resynchronised to the clock before anything reads it.

A direction bit of 1 turns its pin into an input and releases the driver. A direction bit of 0 makes the pin an output that carries the matching data bit. When a data register is read, input bits return the synchronised pin level and output bits return the stored value. Each channel has its own width and its own per-bit reset defaults. A parameter can remove the second channel completely.

Top module: `gpio_regfile`

## Requirements
- R1: While `rst` is high and after it falls, each data register holds its reset parameter, each direction register holds its reset parameter (both cut to the channel width), and `rdata` is 0.
- R2: The register offsets decode on byte address bits [3:2]: 0x00 is channel 1 data, 0x04 is channel 1 direction, 0x08 is channel 2 data and 0x0C is channel 2 direction.
- R3: A write with `wr_en` high changes only the bits in byte lanes whose `be` bit is 1. Lane k covers bits 8k+7 down to 8k.
- R4: `chN_out` always carries the channel's data register, and a write takes effect on the clock edge that samples it.
- R5: `chN_hiz` always carries the channel's direction register (1 = input, driver off). A direction read returns that register.
- R6: A data read returns the synchronised pin bit where the direction bit is 1 and the stored bit where it is 0.
- R7: `rdata` is registered. It shows the register selected by `addr` at the previous edge. A read that coincides with a write returns the value from before the write.
- R8: A pin change made before edge k shows on `chN_sync` after edge k+1 (two flops), and not after edge k.
- R9: An address with bits [1:0] not zero, or with any bit above bit 3 set, reads 0, and a write to it changes no register.
- R10: Channel widths are independent. Data and direction bits at or above a channel's width read as 0, and writes to them are dropped.
- R11: With `DUAL` = 0, offsets 0x08 and 0x0C read 0 and ignore writes, `ch2_out` and `ch2_sync` are 0, and `ch2_hiz` is all ones.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| be | input | 4 | Byte-lane write enables |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| ch1_pin | input | CH1_W | Channel 1 pin levels |
| ch1_out | output | CH1_W | Channel 1 output values |
| ch1_hiz | output | CH1_W | Channel 1 driver disable, 1 = input |
| ch1_sync | output | CH1_W | Channel 1 synchronised pin levels |
| ch2_pin | input | CH2_W | Channel 2 pin levels |
| ch2_out | output | CH2_W | Channel 2 output values |
| ch2_hiz | output | CH2_W | Channel 2 driver disable, 1 = input |
| ch2_sync | output | CH2_W | Channel 2 synchronised pin levels |

## Verification
The hardest case to reach is a data read in which a single word mixes live pin bits with stored bits, while the pin levels and the direction bits both move randomly. The expected value is only defined once the synchroniser has settled. The stimulus therefore changes pins only in dedicated idle steps that last three cycles, and between those steps it scatters random byte-lane writes to both direction registers. Most data reads then return a different mix of sources. Directed steps cover the two-flop latency edge by edge, a read that lands on a write, misaligned offsets, and a second instance built with one channel.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int BUS_W  = 32;
  localparam int LANES  = BUS_W / 8;
  localparam int WORD_LSB = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_D1,
    SEL_T1,
    SEL_D2,
    SEL_T2
  } reg_sel_e;

  localparam logic [1:0] IDX_D1 = 2'd0;
  localparam logic [1:0] IDX_T1 = 2'd1;
  localparam logic [1:0] IDX_D2 = 2'd2;
  localparam logic [1:0] IDX_T2 = 2'd3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_decode.sv
module gpio_decode
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter bit DUAL   = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam int HI_W = ADDR_W - 4;

  logic aligned;
  logic in_window;

  always_comb begin
    aligned   = (addr[1:0] == 2'b00);
    in_window = (addr[ADDR_W-1:4] == HI_W'(0));
    sel       = SEL_NONE;
    if (aligned && in_window) begin
      unique case (addr[3:2])
        IDX_D1: sel = SEL_D1;
        IDX_T1: sel = SEL_T1;
        IDX_D2: sel = DUAL ? SEL_D2 : SEL_NONE;
        IDX_T2: sel = DUAL ? SEL_T2 : SEL_NONE;
        default: sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int          W        = 32,
  parameter logic [31:0] DATA_RST = 32'h0000_0000,
  parameter logic [31:0] DIR_RST  = 32'hFFFF_FFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_data,
  input  logic             wr_dir,
  input  logic [LANES-1:0] be,
  input  logic [BUS_W-1:0] wdata,
  input  logic [W-1:0]     pin_sync,
  output logic [W-1:0]     data_q,
  output logic [W-1:0]     dir_q,
  output logic [BUS_W-1:0] rd_data,
  output logic [BUS_W-1:0] rd_dir
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= DATA_RST[W-1:0];
      dir_q  <= DIR_RST[W-1:0];
    end else begin
      for (int i = 0; i < W; i++) begin
        if (be[i/8]) begin
          if (wr_data) data_q[i] <= wdata[i];
          if (wr_dir)  dir_q[i]  <= wdata[i];
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    rd_dir  = '0;
    for (int i = 0; i < W; i++) begin
      rd_data[i] = dir_q[i] ? pin_sync[i] : data_q[i];
      rd_dir[i]  = dir_q[i];
    end
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter bit          DUAL         = 1'b1,
  parameter int          CH1_W        = 32,
  parameter int          CH2_W        = 32,
  parameter logic [31:0] CH1_DATA_RST = 32'h0000_0000,
  parameter logic [31:0] CH1_DIR_RST  = 32'hFFFF_FFFF,
  parameter logic [31:0] CH2_DATA_RST = 32'h0000_0000,
  parameter logic [31:0] CH2_DIR_RST  = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [CH1_W-1:0]  ch1_pin,
  output logic [CH1_W-1:0]  ch1_out,
  output logic [CH1_W-1:0]  ch1_hiz,
  output logic [CH1_W-1:0]  ch1_sync,
  input  logic [CH2_W-1:0]  ch2_pin,
  output logic [CH2_W-1:0]  ch2_out,
  output logic [CH2_W-1:0]  ch2_hiz,
  output logic [CH2_W-1:0]  ch2_sync
);
  reg_sel_e   sel;
  logic [31:0] c1_rd_data, c1_rd_dir;
  logic [31:0] c2_rd_data, c2_rd_dir;
  logic [31:0] rd_next;

  gpio_decode #(.ADDR_W(ADDR_W), .DUAL(DUAL)) u_dec (
    .addr (addr),
    .sel  (sel)
  );

  gpio_sync #(.W(CH1_W)) u_sync1 (
    .clk (clk), .rst (rst), .d (ch1_pin), .q (ch1_sync)
  );

  gpio_bank #(.W(CH1_W), .DATA_RST(CH1_DATA_RST), .DIR_RST(CH1_DIR_RST)) u_bank1 (
    .clk      (clk),
    .rst      (rst),
    .wr_data  (wr_en && sel == SEL_D1),
    .wr_dir   (wr_en && sel == SEL_T1),
    .be       (be),
    .wdata    (wdata),
    .pin_sync (ch1_sync),
    .data_q   (ch1_out),
    .dir_q    (ch1_hiz),
    .rd_data  (c1_rd_data),
    .rd_dir   (c1_rd_dir)
  );

  generate
    if (DUAL) begin : g_ch2
      gpio_sync #(.W(CH2_W)) u_sync2 (
        .clk (clk), .rst (rst), .d (ch2_pin), .q (ch2_sync)
      );

      gpio_bank #(.W(CH2_W), .DATA_RST(CH2_DATA_RST), .DIR_RST(CH2_DIR_RST)) u_bank2 (
        .clk      (clk),
        .rst      (rst),
        .wr_data  (wr_en && sel == SEL_D2),
        .wr_dir   (wr_en && sel == SEL_T2),
        .be       (be),
        .wdata    (wdata),
        .pin_sync (ch2_sync),
        .data_q   (ch2_out),
        .dir_q    (ch2_hiz),
        .rd_data  (c2_rd_data),
        .rd_dir   (c2_rd_dir)
      );
    end else begin : g_no_ch2
      assign ch2_sync   = '0;
      assign ch2_out    = '0;
      assign ch2_hiz    = '1;
      assign c2_rd_data = '0;
      assign c2_rd_dir  = '0;
    end
  endgenerate

  always_comb begin
    unique case (sel)
      SEL_D1:  rd_next = c1_rd_data;
      SEL_T1:  rd_next = c1_rd_dir;
      SEL_D2:  rd_next = c2_rd_data;
      SEL_T2:  rd_next = c2_rd_dir;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/gpio_regfile_chk.sv
module gpio_regfile_chk #(
  parameter int ADDR_W = 8,
  parameter bit DUAL   = 1'b1,
  parameter int CH1_W  = 32,
  parameter int CH2_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [31:0]       rdata,
  input logic [CH1_W-1:0]  ch1_out,
  input logic [CH1_W-1:0]  ch1_hiz,
  input logic [CH2_W-1:0]  ch2_out,
  input logic [CH2_W-1:0]  ch2_hiz,
  input logic [CH2_W-1:0]  ch2_sync
);
  logic hit_d1, hit_t1, stray;

  always_comb begin
    hit_d1 = (addr == ADDR_W'(8'h00));
    hit_t1 = (addr == ADDR_W'(8'h04));
    stray  = (addr[1:0] != 2'b00) || ((addr >> 4) != '0);
  end

  // R4: channel 1 output value moves only after a write to its data offset
  a_r4_out_holds: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && hit_d1) |=> $stable(ch1_out));

  // R5: channel 1 direction moves only after a write to its direction offset
  a_r5_hiz_holds: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && hit_t1) |=> $stable(ch1_hiz));

  // R9: unmapped addresses read zero
  a_r9_stray_reads_zero: assert property (@(posedge clk) disable iff (rst)
    stray |=> (rdata == 32'h0));

  // R10: bits above the channel 1 width read zero
  a_r10_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (hit_d1 || hit_t1) |=> ((rdata >> CH1_W) == 32'h0));

  generate
    if (!DUAL) begin : g_single
      // R11: absent channel 2 drives a fixed idle state
      a_r11_ch2_idle: assert property (@(posedge clk) disable iff (rst)
        (ch2_hiz == '1) && (ch2_out == '0) && (ch2_sync == '0));
    end
  endgenerate
endmodule

bind gpio_regfile gpio_regfile_chk #(
  .ADDR_W (ADDR_W),
  .DUAL   (DUAL),
  .CH1_W  (CH1_W),
  .CH2_W  (CH2_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .addr     (addr),
  .wr_en    (wr_en),
  .rdata    (rdata),
  .ch1_out  (ch1_out),
  .ch1_hiz  (ch1_hiz),
  .ch2_out  (ch2_out),
  .ch2_hiz  (ch2_hiz),
  .ch2_sync (ch2_sync)
);

// File: tb/tb_gpio_regfile.sv
module tb_gpio_regfile;
  localparam logic [31:0] M1 = 32'h0000_0FFF;
  localparam logic [31:0] M2 = 32'h000F_FFFF;
  localparam logic [31:0] D1R = 32'h0000_0A5C;
  localparam logic [31:0] T1R = 32'hFFFF_F0F0;
  localparam logic [31:0] D2R = 32'h000C_3001;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = 8'h40;
  logic        wr_en = 1'b0;
  logic [3:0]  be = 4'h0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic [11:0] p1 = '0, o1, h1, s1;
  logic [19:0] p2 = '0, o2, h2, s2;

  logic [31:0] rdata_s;
  logic [7:0]  sp1 = '0, so1, sh1, ss1;
  logic [3:0]  sp2 = '0, so2, sh2, ss2;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_d1, m_t1, m_d2, m_t2;

  always #4 clk = ~clk;

  gpio_regfile #(.ADDR_W(8), .DUAL(1'b1), .CH1_W(12), .CH2_W(20),
    .CH1_DATA_RST(D1R), .CH1_DIR_RST(T1R), .CH2_DATA_RST(D2R)) dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .be(be), .wdata(wdata),
    .rdata(rdata), .ch1_pin(p1), .ch1_out(o1), .ch1_hiz(h1), .ch1_sync(s1),
    .ch2_pin(p2), .ch2_out(o2), .ch2_hiz(h2), .ch2_sync(s2));

  gpio_regfile #(.ADDR_W(8), .DUAL(1'b0), .CH1_W(8), .CH2_W(4)) dut_single (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .be(be), .wdata(wdata),
    .rdata(rdata_s), .ch1_pin(sp1), .ch1_out(so1), .ch1_hiz(sh1), .ch1_sync(ss1),
    .ch2_pin(sp2), .ch2_out(so2), .ch2_hiz(sh2), .ch2_sync(ss2));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] en, input logic [31:0] msk);
    logic [31:0] r = old;
    for (int k = 0; k < 4; k++) if (en[k]) r[8*k +: 8] = d[8*k +: 8];
    return r & msk;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00:   return ((m_d1 & ~m_t1) | ({20'h0, p1} & m_t1)) & M1;
      8'h04:   return m_t1;
      8'h08:   return ((m_d2 & ~m_t2) | ({12'h0, p2} & m_t2)) & M2;
      8'h0C:   return m_t2;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_wr(input logic [7:0] a, input logic [3:0] e, input logic [31:0] d);
    case (a)
      8'h00: m_d1 = merge(m_d1, d, e, M1);
      8'h04: m_t1 = merge(m_t1, d, e, M1);
      8'h08: m_d2 = merge(m_d2, d, e, M2);
      8'h0C: m_t2 = merge(m_t2, d, e, M2);
      default: ;
    endcase
  endtask

  // tasks start and end just after a falling edge
  task automatic do_wr(input logic [7:0] a, input logic [3:0] e, input logic [31:0] d);
    addr = a; be = e; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; be = 4'h0;
    model_wr(a, e, d);
  endtask

  task automatic do_rd(input logic [7:0] a, input string req);
    addr = a; wr_en = 1'b0;
    @(negedge clk);
    chk(rdata == exp_rd(a), req, rdata, exp_rd(a));
  endtask

  task automatic chk_outs(input string req);
    chk({20'h0, o1} == m_d1, req, {20'h0, o1}, m_d1);
    chk({20'h0, h1} == m_t1, req, {20'h0, h1}, m_t1);
    chk({12'h0, o2} == m_d2, req, {12'h0, o2}, m_d2);
    chk({12'h0, h2} == m_t2, req, {12'h0, h2}, m_t2);
  endtask

  task automatic settle();
    addr = 8'h40;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    m_d1 = D1R & M1; m_t1 = T1R & M1; m_d2 = D2R & M2; m_t2 = M2;
    repeat (3) @(negedge clk);
    // R1: reset state held while reset is high
    chk_outs("R1");
    chk(rdata == 32'h0, "R1", rdata, 32'h0);
    chk({24'h0, sh1} == 32'hFF && so1 == 8'h0, "R1", {16'h0, so1, sh1}, 32'h00FF);
    rst = 1'b0;
    @(negedge clk);
    chk_outs("R1");

    // R2 / R5: readback of each offset, direction register defaults
    do_rd(8'h04, "R2");
    do_rd(8'h0C, "R5");
    do_rd(8'h08, "R2");

    // R3: single lane writes
    do_wr(8'h00, 4'b0010, 32'hFFFF_37FF);
    chk_outs("R3");
    do_wr(8'h08, 4'b0100, 32'h0099_0000);
    chk_outs("R3");
    do_rd(8'h08, "R3");

    // R4 / R10: full write into ch1 direction; upper bits dropped
    do_wr(8'h04, 4'hF, 32'hFFFF_F00F);
    chk_outs("R10");
    do_rd(8'h04, "R10");

    // R6: mixed read with known pins
    p1 = 12'hC3A; settle();
    do_rd(8'h00, "R6");

    // R8: two-flop latency edge by edge
    p1 = 12'h555;
    settle();
    p1 = 12'hAAA;
    @(negedge clk);
    chk(s1 == 12'h555, "R8", {20'h0, s1}, 32'h555);
    @(negedge clk);
    chk(s1 == 12'hAAA, "R8", {20'h0, s1}, 32'hAAA);

    // R7: read coincident with write returns the old value
    do_rd(8'h00, "R7");
    v = exp_rd(8'h00);
    do_wr(8'h00, 4'hF, 32'h0000_0123);
    chk(rdata == v, "R7", rdata, v);
    do_rd(8'h00, "R7");

    // R9: misaligned and out-of-window writes ignored, read zero
    do_wr(8'h01, 4'hF, 32'hFFFF_FFFF);
    do_wr(8'h14, 4'hF, 32'hFFFF_FFFF);
    do_wr(8'h86, 4'hF, 32'hFFFF_FFFF);
    chk_outs("R9");
    do_rd(8'h05, "R9");
    do_rd(8'h10, "R9");
    do_rd(8'h84, "R9");

    // R11: single-channel instance ignores channel 2 offsets
    do_wr(8'h08, 4'hF, 32'h0000_000F);
    do_wr(8'h0C, 4'hF, 32'h0000_0000);
    chk(so2 == 4'h0 && sh2 == 4'hF && ss2 == 4'h0, "R11", {20'h0, so2, sh2, ss2}, 32'h0F0);
    addr = 8'h0C; @(negedge clk);
    chk(rdata_s == 32'h0, "R11", rdata_s, 32'h0);
    do_wr(8'h04, 4'hF, 32'h0000_00F0);
    sp1 = 8'h5A; do_wr(8'h00, 4'hF, 32'h0000_0033);
    settle();
    addr = 8'h00; @(negedge clk);
    chk(rdata_s == 32'h53, "R11", rdata_s, 32'h53);

    // random mix
    for (int it = 0; it < 600; it++) begin
      int op = $urandom % 5;
      logic [7:0] a;
      int pick = $urandom % 10;
      a = (pick < 8) ? 8'(4 * (pick % 4)) : 8'($urandom);
      if (op == 0) begin
        p1 = 12'($urandom); p2 = 20'($urandom);
        settle();
      end else if (op == 1 || op == 2) begin
        do_wr(a, 4'($urandom), $urandom);
        chk_outs("R3");
      end else begin
        do_rd(a, "R6");
      end
    end
    finish_run();
  end
endmodule